// File: doc/BRIEF.md
# Integer Compare-to-Predicate Unit

This block compares a 32-bit operand A against a second operand B and turns the result into two predicate bits for a predicated datapath. B comes from one of three places: a register value, a 32-bit constant, or a 20-bit immediate that is sign-extended to 32 bits. A four-bit condition code picks the test. A format bit picks signed or unsigned reading of the general tests.

The raw test result is merged with a gating predicate through AND, OR or XOR. The gating predicate can be inverted first. This gives a true-path predicate and a complement-path predicate, which is how nested if/else regions are set up under an outer predicate. A plain mode passes the test result through and forces the complement output to the hard-wired true value.

An extended mode finishes a multi-word compare. A previous low-word subtraction supplies its carry and its zero flag. The unit then subtracts the high words with that borrow, and counts the result as zero only when both words are zero. Both outputs are registered, so they appear one clock after the inputs.

Top module: `icmp_pred`

## Requirements
- R1: While `rst_n` is low, `pred_t`, `pred_f` and `bad_enc` are 0. Each result appears on the outputs at the first rising clock edge after its inputs are applied.
- R2: `src_sel` selects B. 0 selects `reg_b`, 1 selects `const_b`, 2 selects `imm_b` sign-extended from bit 19, and 3 (reserved) selects `reg_b`.
- R3: The general condition codes are 0 never, 1 less, 2 equal, 3 less-or-equal, 4 greater, 5 not-equal, 6 greater-or-equal and 7 always. With `use_unsigned`=0 they read A and B as two's-complement values.
- R4: With `use_unsigned`=1, the general tests read A and B as unsigned.
- R5: Codes 8 lower, 9 lower-or-same, 10 higher and 11 higher-or-same always compare unsigned, whatever `use_unsigned` holds.
- R6: `bad_enc` is 1 for a code from 8 to 11 with `use_unsigned`=0, and for any code from 12 to 15. Codes 12 to 15 give a test result of 0.
- R7: Let g = `gate_pred` XOR `gate_inv` and c = the test result. `logic_op` 0 (AND), 1 (OR) and 2 (XOR) give `pred_t` = c op g and `pred_f` = (NOT c) op g.
- R8: `logic_op` 3 (plain) gives `pred_t` = c and `pred_f` = 1.
- R9: With `ext_en`=1, the difference is A + ~B + `carry_in`. Less follows the borrow when unsigned, or the sign of the difference when signed. Equal requires a zero difference and `zero_in`=1. A chained pair of compares therefore orders 64-bit values correctly.
- R10: Codes 0 and 7 give 0 and 1 respectively, whatever the operands, `ext_en` and the flags hold.
- R11: Signed less is correct at the ends of the range, for example 0x80000000 < 0x00000001 and 0x7FFFFFFF > 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 32 | Operand A |
| src_sel | input | 2 | Selects the source of B |
| reg_b | input | 32 | Register value for B |
| const_b | input | 32 | Constant value for B |
| imm_b | input | 20 | Immediate value for B, sign-extended |
| cond | input | 4 | Condition code |
| use_unsigned | input | 1 | Selects unsigned reading of the general tests |
| logic_op | input | 2 | Merge operation: AND, OR, XOR or plain |
| ext_en | input | 1 | Enables extended (chained) compare |
| carry_in | input | 1 | Carry from the prior low-word subtraction |
| zero_in | input | 1 | Zero flag from the prior low-word subtraction |
| gate_pred | input | 1 | Gating predicate |
| gate_inv | input | 1 | Inverts the gating predicate |
| pred_t | output | 1 | True-path predicate |
| pred_f | output | 1 | Complement-path predicate |
| bad_enc | output | 1 | Flags an illegal condition/format pair |

## Verification
The bench aims at the overflow corners: the most negative value against small positives, and the most positive value against -1. A design that takes the raw sign bit of the difference inverts its signed answer there. It checks chained 64-bit compares whose high words are equal and whose low words differ. A design that ignores the incoming borrow, or the incoming zero flag, reports equal or the wrong order for these. It also drives unsigned-only codes with the signed format, reserved codes, and immediates with bit 19 set. A missing sign extension, a missing illegal flag, or a format bit that wrongly overrides the unsigned-only tests all change an output there.

// File: rtl/icmp_pred.sv
module icmp_pred #(
  parameter int W     = 32,
  parameter int IMM_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     opnd_a,
  input  logic [1:0]       src_sel,
  input  logic [W-1:0]     reg_b,
  input  logic [W-1:0]     const_b,
  input  logic [IMM_W-1:0] imm_b,
  input  logic [3:0]       cond,
  input  logic             use_unsigned,
  input  logic [1:0]       logic_op,
  input  logic             ext_en,
  input  logic             carry_in,
  input  logic             zero_in,
  input  logic             gate_pred,
  input  logic             gate_inv,
  output logic             pred_t,
  output logic             pred_f,
  output logic             bad_enc
);
  localparam int PAD = W - IMM_W;

  logic [W-1:0] b_val;
  logic [W:0]   sum;
  logic [W-1:0] diff;
  logic         ovf, lt, eq, res, g, nt, nf;

  always_comb begin
    case (src_sel)
      2'd1:    b_val = const_b;
      2'd2:    b_val = {{PAD{imm_b[IMM_W-1]}}, imm_b};
      default: b_val = reg_b;
    endcase
  end

  assign sum  = {1'b0, opnd_a} + {1'b0, ~b_val} + {{W{1'b0}}, (ext_en ? carry_in : 1'b1)};
  assign diff = sum[W-1:0];
  assign ovf  = (opnd_a[W-1] ^ b_val[W-1]) & (diff[W-1] ^ opnd_a[W-1]);
  assign lt   = (use_unsigned | cond[3]) ? ~sum[W] : (diff[W-1] ^ ovf);
  assign eq   = (diff == '0) & (~ext_en | zero_in);
  assign g    = gate_pred ^ gate_inv;

  always_comb begin
    case (cond)
      4'd1, 4'd8:  res = lt;
      4'd2:        res = eq;
      4'd3, 4'd9:  res = lt | eq;
      4'd4, 4'd10: res = ~(lt | eq);
      4'd5:        res = ~eq;
      4'd6, 4'd11: res = ~lt;
      4'd7:        res = 1'b1;
      default:     res = 1'b0;
    endcase
  end

  always_comb begin
    case (logic_op)
      2'd0:    begin nt = res & g;  nf = ~res & g;  end
      2'd1:    begin nt = res | g;  nf = ~res | g;  end
      2'd2:    begin nt = res ^ g;  nf = ~res ^ g;  end
      default: begin nt = res;      nf = 1'b1;      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_t  <= 1'b0;
      pred_f  <= 1'b0;
      bad_enc <= 1'b0;
    end else begin
      pred_t  <= nt;
      pred_f  <= nf;
      bad_enc <= (cond[3] & ~cond[2] & ~use_unsigned) | (cond[3] & cond[2]);
    end
  end
endmodule

module icmp_pred_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] opnd_a,
  input logic [1:0]  src_sel,
  input logic [31:0] reg_b,
  input logic [3:0]  cond,
  input logic        use_unsigned,
  input logic [1:0]  logic_op,
  input logic        ext_en,
  input logic        pred_t,
  input logic        pred_f,
  input logic        bad_enc
);
  p_and_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_op == 2'd0) |=> !(pred_t && pred_f));
  p_or_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_op == 2'd1) |=> (pred_t || pred_f));
  p_xor_differ_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_op == 2'd2) |=> (pred_t != pred_f));
  p_plain_true_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_op == 2'd3) |=> pred_f);
  p_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_unsigned && cond[3] && !cond[2]) |=> bad_enc);
  p_never_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'd0 && logic_op == 2'd0) |=> !pred_t);
  p_always_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 4'd7 && logic_op == 2'd3) |=> pred_t);
  p_self_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && cond == 4'd2 && logic_op == 2'd3 && src_sel == 2'd0 && opnd_a == reg_b) |=> pred_t);
endmodule

bind icmp_pred icmp_pred_chk u_chk (
  .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .src_sel(src_sel), .reg_b(reg_b),
  .cond(cond), .use_unsigned(use_unsigned), .logic_op(logic_op), .ext_en(ext_en),
  .pred_t(pred_t), .pred_f(pred_f), .bad_enc(bad_enc)
);

// File: tb/icmp_pred_test.sv
`timescale 1ns/1ps
module icmp_pred_test;
  logic clk = 0;
  logic rst_n = 0;
  logic [31:0] a = 0, rb = 0, cb = 0;
  logic [19:0] ib = 0;
  logic [1:0]  sel = 0, op = 0;
  logic [3:0]  cnd = 0;
  logic uns = 0, ext = 0, cf = 0, zf = 0, gp = 0, gi = 0;
  logic pt, pf, bad;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  icmp_pred uut (
    .clk(clk), .rst_n(rst_n), .opnd_a(a), .src_sel(sel), .reg_b(rb), .const_b(cb),
    .imm_b(ib), .cond(cnd), .use_unsigned(uns), .logic_op(op), .ext_en(ext),
    .carry_in(cf), .zero_in(zf), .gate_pred(gp), .gate_inv(gi),
    .pred_t(pt), .pred_f(pf), .bad_enc(bad)
  );

  function automatic logic [31:0] pick_b();
    case (sel)
      2'd1:    return cb;
      2'd2:    return {{12{ib[19]}}, ib};
      default: return rb;
    endcase
  endfunction

  function automatic bit ref_cmp(logic [31:0] x, logic [31:0] y);
    bit ue = uns || (cnd >= 4'd8);
    longint sx = ue ? longint'({32'b0, x}) : longint'($signed(x));
    longint sy = ue ? longint'({32'b0, y}) : longint'($signed(y));
    longint d = sx - sy - ((ext && !cf) ? 64'sd1 : 64'sd0);
    bit l = d < 0;
    bit e = (d == 0) && (!ext || zf);
    case (cnd)
      4'd1, 4'd8:  return l;
      4'd2:        return e;
      4'd3, 4'd9:  return l || e;
      4'd4, 4'd10: return !(l || e);
      4'd5:        return !e;
      4'd6, 4'd11: return !l;
      4'd7:        return 1'b1;
      default:     return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (a=%h cond=%0d op=%0d sel=%0d uns=%b ext=%b)",
               req, what, got, exp, a, cnd, op, sel, uns, ext);
    end
  endtask

  task automatic go(string req);
    bit c = ref_cmp(a, pick_b());
    bit g = gp ^ gi;
    bit et, ef, eb;
    case (op)
      2'd0: begin et = c & g; ef = !c & g; end
      2'd1: begin et = c | g; ef = !c | g; end
      2'd2: begin et = c ^ g; ef = !c ^ g; end
      default: begin et = c; ef = 1'b1; end
    endcase
    eb = (cnd >= 4'd12) || (cnd >= 4'd8 && !uns);
    @(negedge clk);
    chk(req, "pred_t", pt, et);
    chk(req, "pred_f", pf, ef);
    chk(req, "bad_enc", bad, eb);
  endtask

  task automatic plain(logic [31:0] x, logic [31:0] y, logic [3:0] c, logic u);
    a = x; rb = y; sel = 0; cnd = c; uns = u; op = 3; ext = 0; cf = 0; zf = 0;
  endtask

  task automatic chain64(logic [63:0] x, logic [63:0] y, logic [3:0] c, logic u);
    logic lo_cf = x[31:0] >= y[31:0];
    logic lo_zf = x[31:0] == y[31:0];
    bit ue = u || c >= 4'd8;
    bit l = ue ? (x < y) : ($signed(x) < $signed(y));
    bit e = x == y;
    bit exp;
    case (c)
      4'd1, 4'd8:  exp = l;
      4'd2:        exp = e;
      4'd3, 4'd9:  exp = l || e;
      4'd4, 4'd10: exp = !(l || e);
      4'd5:        exp = !e;
      4'd6, 4'd11: exp = !l;
      4'd7:        exp = 1'b1;
      default:     exp = 1'b0;
    endcase
    a = x[63:32]; rb = y[63:32]; sel = 0; cnd = c; uns = u; op = 3;
    ext = 1; cf = lo_cf; zf = lo_zf;
    @(negedge clk);
    chk("R9", "64-bit pred_t", pt, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'h1c0ffee);
    a = 32'hFFFF_FFFF; rb = 32'hFFFF_FFFF; cnd = 4'd7; op = 2'd1; gp = 1;
    repeat (3) @(negedge clk);
    chk("R1", "reset pred_t", pt, 1'b0);
    chk("R1", "reset pred_f", pf, 1'b0);
    chk("R1", "reset bad_enc", bad, 1'b0);
    rst_n = 1;
    gp = 0; gi = 0;

    plain(32'hFFFF_FFFF, 0, 4'd2, 0); sel = 2; ib = 20'hFFFFF; go("R2");
    plain(32'h000F_FFFF, 0, 4'd2, 0); sel = 2; ib = 20'hFFFFF; go("R2");
    plain(32'h1234_5678, 0, 4'd2, 0); sel = 1; cb = 32'h1234_5678; go("R2");
    plain(32'h8000_0000, 32'h1, 4'd1, 0); go("R11");
    plain(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'd4, 0); go("R11");
    plain(32'h8000_0000, 32'h7FFF_FFFF, 4'd3, 0); go("R11");
    plain(32'h8000_0000, 32'h1, 4'd1, 1); go("R4");
    plain(32'hFFFF_FFFF, 32'h1, 4'd6, 1); go("R4");
    plain(32'hFFFF_FFFF, 32'h1, 4'd1, 0); go("R3");
    plain(32'h5, 32'h5, 4'd5, 0); go("R3");
    plain(32'h8000_0000, 32'h1, 4'd8, 0); go("R5");
    plain(32'h8000_0000, 32'h1, 4'd10, 0); go("R5");
    plain(32'h3, 32'h3, 4'd9, 1); go("R5");
    plain(32'h1, 32'h2, 4'd13, 1); go("R6");
    plain(32'h1, 32'h2, 4'd15, 0); go("R6");
    plain(32'h1, 32'h9, 4'd7, 0); ext = 1; cf = 0; zf = 0; go("R10");
    plain(32'h9, 32'h9, 4'd0, 0); ext = 1; cf = 1; zf = 1; go("R10");
    for (int o = 0; o < 3; o++)
      for (int k = 0; k < 4; k++) begin
        plain(32'h1, 32'h2, 4'd1, 0); op = o[1:0]; gp = k[0]; gi = k[1]; go("R7");
        plain(32'h2, 32'h1, 4'd1, 0); op = o[1:0]; gp = k[0]; gi = k[1]; go("R7");
      end
    plain(32'h2, 32'h1, 4'd1, 0); gp = 1; go("R8");
    plain(32'h0, 32'h0, 4'd2, 0); ext = 1; cf = 1; zf = 0; go("R9");
    plain(32'h5, 32'h5, 4'd1, 1); ext = 1; cf = 0; zf = 0; go("R9");

    chain64(64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 4'd2, 0);
    chain64(64'h0000_0001_0000_0000, 64'h0000_0001_0000_0001, 4'd1, 0);
    chain64(64'h0000_0001_0000_0002, 64'h0000_0001_0000_0001, 4'd3, 0);
    chain64(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 4'd1, 0);
    chain64(64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 4'd8, 1);
    chain64(64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 4'd4, 0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] x = {$urandom, $urandom};
      logic [63:0] y = (i % 4 == 0) ? {x[63:32], $urandom} : {$urandom, $urandom};
      if (i % 8 == 1) y = x;
      chain64(x, y, 4'($urandom_range(0, 11)), 1'($urandom));
    end

    for (int i = 0; i < 3000; i++) begin
      a = $urandom; rb = $urandom; cb = $urandom; ib = 20'($urandom);
      if (i % 5 == 0) rb = a;
      if (i % 7 == 0) a = {1'b1, 31'($urandom_range(0, 3))};
      sel = 2'($urandom); cnd = 4'($urandom); op = 2'($urandom);
      uns = 1'($urandom); ext = 1'($urandom); zf = 1'($urandom);
      cf = zf ? 1'b1 : 1'($urandom);
      gp = 1'($urandom); gi = 1'($urandom);
      go("R7");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule